// File: doc/BRIEF.md
# Iterative Shift-Add Integer Multiplier

This block multiplies two integer operands of WIDTH bits (32 by default) and returns a product of twice that width. It has a single register that holds both the partial product and the multiplier, and one adder. A one-cycle start request captures the multiplicand, the multiplier and a signed/unsigned select. The block then runs one add-and-shift step per clock for WIDTH clocks. After the last step it pulses done and presents the product as a high word and a low word.

On each step the low bit of the combined register decides whether the multiplicand is added to its upper half. The register then shifts right by one bit in the same clock. The low half starts as the multiplier and shrinks while the product grows in from the top. In signed mode the block first negates both operands when the multiplier is negative. The multiplier is then never negative, and any sign rests on the multiplicand. The upper half is added as a signed value, and the sign of the sum fills the vacated top bit. The high and low result words stay unchanged until the next accepted start, so the two words can be read one after the other.

Top module: `shiftadd_mul`

## Requirements
- R1: A start request while idle is accepted at that clock edge. In the next cycle busy is 1 and the high word reads 0.
- R2: done rises exactly WIDTH clock cycles (32 by default) after the edge that accepted the start.
- R3: In unsigned mode (mode input 0) both operands are unsigned. {hi, lo} equals their full 2*WIDTH-bit unsigned product, carries included.
- R4: In signed mode (mode input 1) both operands are two's complement. {hi, lo} equals their 2*WIDTH-bit two's-complement product, for any mix of signs.
- R5: In signed mode the most negative multiplier (only the top bit set) still gives the correct product. Its magnitude is treated as 2^(WIDTH-1).
- R6: A start request while busy has no effect. The running operation completes at its original time with its original result.
- R7: While idle with no start request, hi and lo keep their values.
- R8: After a synchronous active-low reset, busy, done, hi and lo are all 0.
- R9: done is high for exactly one cycle, and busy is 0 in that cycle.
- R10: 21 times 5 gives 105, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, sampled at the rising edge |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| hi_o | output | WIDTH | Upper half of the product |
| lo_o | output | WIDTH | Lower half of the product |

## Verification
A wrong sign fill or a lost carry in the upper-half add changes the high word at the first done pulse. It only shows for operand patterns whose partial sums reach the top bit, so random operands are mixed with the extreme values. An iteration counter that is off by one moves done away from exactly WIDTH cycles. It also leaves the product scaled by a power of two, and both errors are visible within one operation. A start that leaks in while busy corrupts the result of the operation already running.

// File: rtl/mul_pkg.sv
// Package: shared types for the iterative multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mul_pkg;
    // Operand interpretation selected at start.
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mul_mode_e;
endpackage

// File: rtl/mul_operand_prep.sv
// Module: mul_operand_prep
// Purpose: prepares the operands at start. In signed mode with a negative
// multiplier it negates both operands, so the multiplier is non-negative
// and the sign sits on the multiplicand. The multiplicand is widened by one
// bit so that negating the most negative value stays representable.
// Assumes: purely combinational; the caller registers the outputs.
module mul_operand_prep
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    input  mul_mode_e        mode_i,
    output logic [WIDTH:0]   mcand_x_o,
    output logic [WIDTH-1:0] mplier_x_o
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic           flip;
    logic [WIDTH:0] mcand_ext;

    // Decide whether both operands are negated.
    always_comb begin
        flip = (mode_i == MODE_SIGNED) && mplier_i[WIDTH-1];
    end

    // Extend the multiplicand according to the mode.
    always_comb begin
        if (mode_i == MODE_SIGNED) mcand_ext = {mcand_i[WIDTH-1], mcand_i};
        else                       mcand_ext = {1'b0, mcand_i};
    end

    // Apply the conditional negation.
    always_comb begin
        if (flip) begin
            mcand_x_o  = ~mcand_ext + 1'b1;
            mplier_x_o = ~mplier_i + 1'b1;
        end else begin
            mcand_x_o  = mcand_ext;
            mplier_x_o = mplier_i;
        end
    end

    // R5: after negation the multiplier is non-negative, or it is the most
    // negative pattern, which is read as the magnitude 2^(WIDTH-1).
    always_comb begin
        if (flip) begin
            p_mplier_magnitude_r5: assert (!mplier_x_o[WIDTH-1] || mplier_x_o == MOST_NEG);
        end
    end
endmodule

// File: rtl/mul_sequencer.sv
// Module: mul_sequencer
// Purpose: counts the add-shift iterations, keeps the busy flag, gives a
// one-cycle done pulse after the last step, and blocks starts while busy.
// Assumes: start_i is synchronous to clk; reset is synchronous, active low.
module mul_sequencer #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] STEPS = CNT_W'(WIDTH);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    // Accept a start only while idle; step on every busy cycle.
    always_comb begin
        load_o = start_i && !busy_q;
        step_o = busy_q;
    end

    // Iteration counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                cnt_q  <= STEPS;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    // Checker counter: cycles spent since the accepted start.
    logic [CNT_W:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (load_o)  lat_q <= '0;
        else if (busy_q)  lat_q <= lat_q + 1'b1;
    end

    // R2: done arrives exactly WIDTH cycles after the accepted start.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> lat_q == (CNT_W+1)'(WIDTH));

    // R9: done lasts a single cycle and never overlaps busy.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R6: a start while busy does not restart the count.
    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && cnt_q > CNT_W'(1)) |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/mul_datapath.sv
// Module: mul_datapath
// Purpose: the combined product/multiplier register and its adder. On load
// the low half takes the prepared multiplier and the high half clears. On
// each step the low bit selects the multiplicand or zero. The addend goes
// into a WIDTH+1 bit sum with the upper half, and the register shifts right
// in the same cycle. Bit WIDTH of the sum fills the top bit: the carry in
// unsigned mode, the sign in signed mode.
// Assumes: load and step are never high together.
module mul_datapath
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  mul_mode_e          mode_i,
    input  logic [WIDTH:0]     mcand_x_i,
    input  logic [WIDTH-1:0]   mplier_x_i,
    output logic [2*WIDTH-1:0] prod_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    prod_q;
    logic [WIDTH:0]   mcand_q;
    mul_mode_e        mode_q;
    logic [WIDTH:0]   upper_ext;
    logic [WIDTH:0]   addend;
    logic [WIDTH:0]   sum;
    logic [PW-1:0]    prod_next;

    // Extend the upper half according to the captured mode.
    always_comb begin
        if (mode_q == MODE_SIGNED) upper_ext = {prod_q[PW-1], prod_q[PW-1:WIDTH]};
        else                       upper_ext = {1'b0, prod_q[PW-1:WIDTH]};
    end

    // Select the multiplicand or zero from the low bit, then add.
    always_comb begin
        addend    = prod_q[0] ? mcand_q : '0;
        sum       = upper_ext + addend;
        prod_next = {sum, prod_q[WIDTH-1:1]};
    end

    // Product register, multiplicand and mode storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            mode_q  <= MODE_UNSIGNED;
        end else if (load_i) begin
            prod_q  <= {{WIDTH{1'b0}}, mplier_x_i};
            mcand_q <= mcand_x_i;
            mode_q  <= mode_i;
        end else if (step_i) begin
            prod_q <= prod_next;
        end
    end

    assign prod_o = prod_q;

    // R3: an unsigned step with a clear low bit is a pure logical shift.
    p_shift_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !prod_q[0] && mode_q == MODE_UNSIGNED)
        |=> prod_q == {1'b0, $past(prod_q[PW-1:1])});

    // R4: a signed step with a clear low bit keeps the sign of the upper half.
    p_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !prod_q[0] && mode_q == MODE_SIGNED)
        |=> prod_q[PW-1] == $past(prod_q[PW-1]));
endmodule

// File: rtl/shiftadd_mul.sv
// Module: shiftadd_mul (top)
// Purpose: iterative signed/unsigned multiplier. WIDTH add-shift steps per
// product; the high and low result words hold until the next accepted start.
// Assumes: synchronous active-low reset; operands and mode are valid in the
// cycle start_i is high.
module shiftadd_mul
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    logic               load;
    logic               step;
    mul_mode_e          mode;
    logic [WIDTH:0]     mcand_x;
    logic [WIDTH-1:0]   mplier_x;
    logic [2*WIDTH-1:0] prod;

    // Map the select input onto the mode type.
    always_comb begin
        mode = signed_i ? MODE_SIGNED : MODE_UNSIGNED;
    end

    mul_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .mcand_i    (mcand_i),
        .mplier_i   (mplier_i),
        .mode_i     (mode),
        .mcand_x_o  (mcand_x),
        .mplier_x_o (mplier_x)
    );

    mul_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .mode_i     (mode),
        .mcand_x_i  (mcand_x),
        .mplier_x_i (mplier_x),
        .prod_o     (prod)
    );

    assign hi_o = prod[2*WIDTH-1:WIDTH];
    assign lo_o = prod[WIDTH-1:0];

    // R1: an accepted start makes the block busy with a cleared high word.
    p_load_clears_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o && hi_o == '0);

    // R7: idle without a start leaves both result words untouched.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(hi_o) && $stable(lo_o));
endmodule

// File: tb/tb_shiftadd_mul.sv
// Bench for shiftadd_mul: directed corners plus seeded random operands,
// checked against products computed with wide arithmetic.
module tb_shiftadd_mul;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    shiftadd_mul #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a,
                                                input logic [W-1:0] b,
                                                input logic sgn);
        logic [2*W-1:0] ea, eb;
        ea = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;  // low 2W bits of the product are exact in both modes
    endfunction

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one multiply; optionally poke a start at cycle 'poke' while busy.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic sgn, input string req, input int poke);
        logic [2*W-1:0] exp;
        logic [2*W-1:0] got;
        int cyc;
        exp = ref_prod(a, b, sgn);
        @(negedge clk);
        mcand_i = a; mplier_i = b; signed_i = sgn; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && hi_o == '0, "R1", {31'b0, busy_o, hi_o}, {31'b0, 1'b1, {W{1'b0}}});
        cyc = 0;
        while (!done_o && cyc < 100) begin
            if (poke > 0 && cyc == poke) begin
                mcand_i = ~a; mplier_i = b ^ 32'h5A5A_1234; signed_i = ~sgn; start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        got = {hi_o, lo_o};
        check(cyc == W, poke > 0 ? "R6" : "R2", 64'(cyc), 64'(W));
        check(got == exp, req, got, exp);
        check(!busy_o, "R9", {63'b0, busy_o}, '0);
        @(negedge clk);
        check(!done_o, "R9", {63'b0, done_o}, '0);
        repeat (2) @(negedge clk);
        check({hi_o, lo_o} == exp, "R7", {hi_o, lo_o}, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] ra, rb;
        logic rs;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R8: reset state
        check(!busy_o && !done_o && hi_o == '0 && lo_o == '0, "R8",
              {hi_o, lo_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R8", {62'b0, busy_o, done_o}, '0);

        // R10: worked example
        run_op(32'd21, 32'd5, 1'b0, "R10", 0);
        run_op(32'd21, 32'd5, 1'b1, "R10", 0);
        // R3: unsigned extremes
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3", 0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, "R3", 0);
        run_op(32'h0000_0000, 32'hDEAD_BEEF, 1'b0, "R3", 0);
        run_op(32'hDEAD_BEEF, 32'h0000_0001, 1'b0, "R3", 0);
        // R4: signed mixes
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R4", 0);
        run_op(32'hFFFF_FFF9, 32'd13, 1'b1, "R4", 0);
        run_op(32'd13, 32'hFFFF_FFF9, 1'b1, "R4", 0);
        run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R4", 0);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4", 0);
        // R5: most negative multiplier
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R5", 0);
        run_op(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R5", 0);
        run_op(32'h0000_0003, 32'h8000_0000, 1'b1, "R5", 0);
        // R6: starts while busy are ignored
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R6", 5);
        run_op(32'hF00D_CAFE, 32'h8765_4321, 1'b1, "R6", 31);
        // Random operands in both modes
        for (int i = 0; i < 200; i++) begin
            ra = $urandom();
            rb = $urandom();
            rs = 1'($urandom());
            if (i % 10 == 0) rb[W-1] = 1'b1;
            run_op(ra, rb, rs, rs ? "R4" : "R3", 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule